// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

The block turns one read or write request into the command sequence an SDRAM expects: open the row, issue the column command, then close the row. At most one row is open at any time, and the row is closed after every access. The user side is a valid/ready request port. It carries a packed address `{bank, row, column}`, a direction bit, an auto-precharge flag, and a whole burst of write data and byte masks. Read data comes back one word per cycle, each with a valid strobe.

On the memory side the block drives the active-low select and strobe pins, the bank and address lines, the data bus with its output enable, and the byte masks. Wait counters, set by parameters, enforce row-to-column delay, CAS latency, write recovery and precharge time. The read precharge is placed CL−1 cycles before the last data word. The write precharge is placed the write-recovery time after the last written word.

When the auto-precharge flag is set, the block raises A10 on the column command. It then sends a NOP in the slot where the precharge would go and still waits out the precharge time.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins show NOP (cs,ras,cas,we = 0111), ready is high, the data bus is released and read valid is low.
- R2: A request is accepted at a clock edge where valid and ready are both high. In the next cycle the pins show ACTIVE (0011), with the bank taken from the top BANK_W bits of the address and the row taken from the next ROW_W bits.
- R3: READ (0101) or WRITE (0100) follows exactly T_RCD cycles after ACTIVE, on the same bank. Address bits [COL_W-1:0] carry the column, which is the low bits of the request address. Bit 10 carries the auto-precharge flag, and every other address bit is zero.
- R4: The data bus is sampled CAS_LAT cycles after READ, once per cycle for BURST_LEN cycles. Each sampled word appears on rdata_o, with rdata_valid_o high, one cycle after it was sampled, in burst order.
- R5: Write word i is bits [i*DATA_W +: DATA_W] of the write data vector. It is driven with the output enable high in cycle WRITE+i. DQM is set to mask bits [i*MASK_W +: MASK_W], where a 1 blocks that byte. Outside write beats the output enable and DQM are low, and the enable is never high with a READ.
- R6: Without auto-precharge, a read is closed by PRECHARGE (0010) exactly BURST_LEN cycles after READ, which is CL−1 cycles before the last data word. The same bank is used and A10 is low.
- R7: Without auto-precharge, a write is closed by PRECHARGE T_WR cycles after the last write word, which is BURST_LEN−1+T_WR cycles after WRITE.
- R8: With auto-precharge, no PRECHARGE is issued. The pins show NOP in that slot and the timing that follows is unchanged.
- R9: Ready returns exactly T_RP cycles after the precharge slot, whether that precharge was issued or implied. No ACTIVE comes earlier than T_RP cycles after a PRECHARGE.
- R10: Only one access is in flight at a time. Ready is low from acceptance until R9 releases it. A request held valid while the block is busy waits, and has no effect on the pins until it is accepted. ACTIVE is never issued while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken at this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_auto_pre_i | input | 1 | Close the row by A10 instead of an explicit precharge |
| req_addr_i | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata_i | input | BURST_LEN*DATA_W | Write burst, word 0 in the low bits |
| req_wmask_i | input | BURST_LEN*MASK_W | Byte masks per word, 1 blocks the byte |
| rdata_o | output | DATA_W | Returned read word |
| rdata_valid_o | output | 1 | rdata_o holds a new word |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank select |
| sd_addr_o | output | ROW_W | Row or column address |
| sd_dq_o | output | DATA_W | Write data to the bus |
| sd_dq_oe_o | output | 1 | Drive the data bus |
| sd_dq_i | input | DATA_W | Read data from the bus |
| sd_dqm_o | output | MASK_W | Byte masks |

## Verification
The assertions assume that nothing else drives the command pins. They also assume the parameters keep CAS_LAT no larger than T_RCD+T_RP+1 and COL_W at most 10, so that read captures of consecutive accesses never overlap and the column never reaches A10. Request fields only matter at the accepting edge. The stimulus therefore holds valid and the fields steady until acceptance, and it sometimes raises valid while the block is busy. The bench drives the data bus every cycle with a value derived from the cycle number, so each returned word shows which cycle it was sampled in.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_TRCD,
    ST_CMD,
    ST_BURST,
    ST_WREC,
    ST_PRE,
    ST_TRP
  } seq_state_e;

  // address bit that selects auto-precharge on a column command
  localparam int AP_BIT = 10;

endpackage

// File: rtl/seq_down_ctr.sv
module seq_down_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/seq_rd_capture.sv
module seq_rd_capture #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);

  // one bit per beat in flight; top bit marks the cycle the word is on the bus
  logic [CAS_LAT-1:0] pipe_q;

  generate
    if (CAS_LAT == 1) begin : g_cl1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= beat_i;
      end
    end else begin : g_cln
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[CAS_LAT-2:0], beat_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= pipe_q[CAS_LAT-1];
      if (pipe_q[CAS_LAT-1]) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 2,
  parameter int T_WR      = 2,
  parameter int T_RP      = 2,
  localparam int MASK_W   = DATA_W / 8,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic                        req_auto_pre_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [BURST_LEN*DATA_W-1:0] req_wdata_i,
  input  logic [BURST_LEN*MASK_W-1:0] req_wmask_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        rdata_valid_o,
  output logic                        sd_cs_no,
  output logic                        sd_ras_no,
  output logic                        sd_cas_no,
  output logic                        sd_we_no,
  output logic [BANK_W-1:0]           sd_ba_o,
  output logic [ROW_W-1:0]            sd_addr_o,
  output logic [DATA_W-1:0]           sd_dq_o,
  output logic                        sd_dq_oe_o,
  input  logic [DATA_W-1:0]           sd_dq_i,
  output logic [MASK_W-1:0]           sd_dqm_o
);

  localparam int T_MAX  = (T_RCD > T_WR) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_WR > T_RP) ? T_WR : T_RP);
  localparam int WAIT_W = $clog2(T_MAX + 1);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  seq_state_e state_q, state_d;

  logic                        wr_q, auto_q;
  logic [BANK_W-1:0]           bank_q;
  logic [ROW_W-1:0]            row_q;
  logic [COL_W-1:0]            col_q;
  logic [BURST_LEN*DATA_W-1:0] wdata_q;
  logic [BURST_LEN*MASK_W-1:0] wmask_q;

  logic              accept;
  logic              wait_load, beat_load;
  logic [WAIT_W-1:0] wait_val, wait_cnt;
  logic [BEAT_W-1:0] beat_val, beat_cnt, beat_idx;
  logic              wait_zero, beat_zero, burst_done;
  logic              wr_beat, rd_beat;
  sdr_cmd_e          cmd;
  logic [ROW_W-1:0]  col_word;

  logic [DATA_W-1:0] wword [BURST_LEN];
  logic [MASK_W-1:0] wmask [BURST_LEN];

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      auto_q  <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      wmask_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write_i;
      auto_q  <= req_auto_pre_i;
      bank_q  <= req_addr_i[ADDR_W-1 -: BANK_W];
      row_q   <= req_addr_i[COL_W +: ROW_W];
      col_q   <= req_addr_i[COL_W-1:0];
      wdata_q <= req_wdata_i;
      wmask_q <= req_wmask_i;
    end
  end

  generate
    for (genvar i = 0; i < BURST_LEN; i++) begin : g_word
      assign wword[i] = wdata_q[i*DATA_W +: DATA_W];
      assign wmask[i] = wmask_q[i*MASK_W +: MASK_W];
    end
  endgenerate

  seq_down_ctr #(.W(WAIT_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wait_load),
    .load_val_i(wait_val),
    .count_o   (wait_cnt)
  );

  seq_down_ctr #(.W(BEAT_W)) u_beat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (beat_load),
    .load_val_i(beat_val),
    .count_o   (beat_cnt)
  );

  assign wait_zero  = (wait_cnt == '0);
  assign beat_zero  = (beat_cnt == '0);
  assign burst_done = ((state_q == ST_CMD) && (BURST_LEN == 1)) ||
                      ((state_q == ST_BURST) && beat_zero);

  // sequencing; every wait state lasts (T - 1) cycles, so the next command lands T after
  always_comb begin
    state_d   = state_q;
    wait_load = 1'b0;
    wait_val  = '0;
    beat_load = 1'b0;
    beat_val  = '0;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_ACT;
      ST_ACT: begin
        if (T_RCD > 1) begin
          wait_load = 1'b1;
          wait_val  = WAIT_W'((T_RCD > 1) ? T_RCD - 2 : 0);
          state_d   = ST_TRCD;
        end else begin
          state_d = ST_CMD;
        end
      end
      ST_TRCD:  if (wait_zero) state_d = ST_CMD;
      ST_CMD: begin
        if (BURST_LEN > 1) begin
          beat_load = 1'b1;
          beat_val  = BEAT_W'((BURST_LEN > 1) ? BURST_LEN - 2 : 0);
          state_d   = ST_BURST;
        end
      end
      ST_BURST: ;
      ST_WREC:  if (wait_zero) state_d = ST_PRE;
      ST_PRE: begin
        if (T_RP > 1) begin
          wait_load = 1'b1;
          wait_val  = WAIT_W'((T_RP > 1) ? T_RP - 2 : 0);
          state_d   = ST_TRP;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TRP:   if (wait_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase

    // burst tail: read closes at once, write waits out recovery
    if (burst_done) begin
      if (!wr_q || T_WR == 1) begin
        state_d = ST_PRE;
      end else begin
        wait_load = 1'b1;
        wait_val  = WAIT_W'((T_WR > 1) ? T_WR - 2 : 0);
        state_d   = ST_WREC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // pin decode
  assign wr_beat  = wr_q  && ((state_q == ST_CMD) || (state_q == ST_BURST));
  assign rd_beat  = !wr_q && ((state_q == ST_CMD) || (state_q == ST_BURST));
  assign beat_idx = (state_q == ST_BURST) ? (BEAT_W'(BURST_LEN - 1) - beat_cnt) : '0;

  always_comb begin
    col_word             = '0;
    col_word[COL_W-1:0]  = col_q;
    col_word[AP_BIT]     = auto_q;
  end

  always_comb begin
    cmd       = CMD_NOP;
    sd_ba_o   = '0;
    sd_addr_o = '0;
    unique case (state_q)
      ST_ACT: begin
        cmd       = CMD_ACT;
        sd_ba_o   = bank_q;
        sd_addr_o = row_q;
      end
      ST_CMD: begin
        cmd       = wr_q ? CMD_WR : CMD_RD;
        sd_ba_o   = bank_q;
        sd_addr_o = col_word;
      end
      ST_PRE: begin
        // auto-precharge: device closes the row itself, slot stays NOP
        cmd       = auto_q ? CMD_NOP : CMD_PRE;
        sd_ba_o   = auto_q ? '0 : bank_q;
      end
      default: ;
    endcase
  end

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd;
  assign sd_dq_oe_o = wr_beat;
  assign sd_dq_o    = wr_beat ? wword[beat_idx] : '0;
  assign sd_dqm_o   = wr_beat ? wmask[beat_idx] : '0;

  seq_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (rd_beat),
    .dq_i   (sd_dq_i),
    .rdata_o(rdata_o),
    .valid_o(rdata_valid_o)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RP  = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic ras_n_i,
  input logic cas_n_i,
  input logic we_n_i,
  input logic a10_i,
  input logic dq_oe_i,
  input logic ready_i
);

  localparam int CW = $clog2(T_RCD + T_RP + 2) + 1;

  logic [3:0]    cmd;
  logic          is_act, is_rw, is_pre, row_open;
  logic [CW-1:0] since_act, since_pre;

  assign cmd    = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '1;
      since_pre <= '1;
      row_open  <= 1'b0;
    end else begin
      since_act <= is_act ? CW'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
      since_pre <= is_pre ? CW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
      if (is_act)                         row_open <= 1'b1;
      else if (is_pre || (is_rw && a10_i)) row_open <= 1'b0;
    end
  end

  AST_RCD_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw |-> since_act >= CW'(T_RCD)) else $error("column command too early"); // R3
  AST_RW_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw |-> row_open) else $error("column command with no open row"); // R3
  AST_PRE_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> !a10_i) else $error("precharge selects all banks"); // R6
  AST_OE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_i) |-> cmd == CMD_WR) else $error("bus driven without write"); // R5
  AST_RD_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD) |-> !dq_oe_i) else $error("bus driven during read"); // R5
  AST_RP_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_pre >= CW'(T_RP)) else $error("activate inside precharge time"); // R9
  AST_SINGLE_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !row_open) else $error("activate with a row open"); // R10
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> cmd == CMD_NOP) else $error("command while idle"); // R10

endmodule

bind sdram_seq sdram_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_i (sd_cs_no),
  .ras_n_i(sd_ras_no),
  .cas_n_i(sd_cas_no),
  .we_n_i (sd_we_no),
  .a10_i  (sd_addr_o[sdram_seq_pkg::AP_BIT]),
  .dq_oe_i(sd_dq_oe_o),
  .ready_i(req_ready_o)
);

// File: tb/sim_sdram_seq.sv
`timescale 1ns/1ps
module sim_sdram_seq;

  localparam int BW = 2, RW = 13, CW = 9, DW = 16, BL = 4;
  localparam int TRCD = 2, CL = 2, TWR = 2, TRP = 2;
  localparam int MW = DW / 8;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RDC = 4'b0101,
                         WRC = 4'b0100, PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [BW+RW+CW-1:0] req_addr = '0;
  logic [BL*DW-1:0] req_wdata = '0;
  logic [BL*MW-1:0] req_wmask = '0;
  logic [DW-1:0] dq_in = '0;
  logic req_ready, rvalid, cs_n, ras_n, cas_n, we_n, oe;
  logic [DW-1:0] rdata, dq_out;
  logic [BW-1:0] ba;
  logic [RW-1:0] addr;
  logic [MW-1:0] dqm;

  int cyc = 0, tests = 0, fails = 0, free_at = 0;
  bit run = 0;

  logic [3:0]    e_cmd [int];
  string         e_tag [int];
  logic [BW-1:0] e_ba  [int];
  logic [RW-1:0] e_addr[int];
  logic [DW-1:0] e_dq  [int];
  logic [MW-1:0] e_dqm [int];
  logic [DW-1:0] e_rd  [int];

  sdram_seq #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .BURST_LEN(BL),
              .T_RCD(TRCD), .CAS_LAT(CL), .T_WR(TWR), .T_RP(TRP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_auto_pre_i(req_ap), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_wmask_i(req_wmask), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n),
    .sd_we_no(we_n), .sd_ba_o(ba), .sd_addr_o(addr), .sd_dq_o(dq_out),
    .sd_dq_oe_o(oe), .sd_dq_i(dq_in), .sd_dqm_o(dqm));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int c);
    return DW'(c * 97 + 961);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
    end
  endtask

  // per-cycle comparison against the model, then drive the bus for this cycle
  always @(negedge clk) begin
    logic [3:0] ec;
    string tg;
    if (run) begin
      ec = e_cmd.exists(cyc) ? e_cmd[cyc] : NOP;
      tg = e_tag.exists(cyc) ? e_tag[cyc] : "R10";
      chk(tg, 32'({cs_n, ras_n, cas_n, we_n}), 32'(ec));
      if (ec != NOP) begin
        chk(tg, 32'(ba), 32'(e_ba[cyc]));
        chk(tg, 32'(addr), 32'(e_addr[cyc]));
      end
      chk("R5", 32'(oe), 32'(e_dq.exists(cyc)));
      if (e_dq.exists(cyc)) chk("R5", 32'(dq_out), 32'(e_dq[cyc]));
      chk("R5", 32'(dqm), e_dqm.exists(cyc) ? 32'(e_dqm[cyc]) : 32'd0);
      chk("R9", 32'(req_ready), 32'(cyc >= free_at));
      chk("R4", 32'(rvalid), 32'(e_rd.exists(cyc)));
      if (e_rd.exists(cyc)) chk("R4", 32'(rdata), 32'(e_rd[cyc]));
    end
    dq_in = pat(cyc);
  end

  // hold valid until the model expects acceptance, then schedule the expected pins
  task automatic issue(input bit wr, input bit ap, input logic [BW-1:0] b,
                       input logic [RW-1:0] r, input logic [CW-1:0] c,
                       input logic [BL*DW-1:0] wd, input logic [BL*MW-1:0] wm);
    bit done = 0;
    int a, t, p;
    logic [RW-1:0] cw;
    while (!done) begin
      @(negedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_ap = ap;
      req_addr = {b, r, c}; req_wdata = wd; req_wmask = wm;
      if (cyc >= free_at) begin
        a = cyc;
        t = a + 1 + TRCD;
        e_cmd[a+1] = ACT; e_tag[a+1] = "R2"; e_ba[a+1] = b; e_addr[a+1] = r;
        cw = '0; cw[CW-1:0] = c; cw[10] = ap;
        e_cmd[t] = wr ? WRC : RDC; e_tag[t] = "R3"; e_ba[t] = b; e_addr[t] = cw;
        if (wr) begin
          for (int i = 0; i < BL; i++) begin
            e_dq[t+i]  = wd[i*DW +: DW];
            e_dqm[t+i] = wm[i*MW +: MW];
          end
          p = t + BL - 1 + TWR;
        end else begin
          for (int i = 0; i < BL; i++) e_rd[t+CL+i+1] = pat(t + CL + i);
          p = t + BL;
        end
        if (ap) begin
          e_cmd[p] = NOP; e_tag[p] = "R8";
        end else begin
          e_cmd[p] = PRE; e_tag[p] = wr ? "R7" : "R6"; e_ba[p] = b; e_addr[p] = '0;
        end
        free_at = p + TRP;
        done = 1;
      end
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP));
    chk("R1", 32'(req_ready), 32'd1);
    rst_ni = 1'b1;
    free_at = cyc;
    @(negedge clk); #1;
    chk("R1", 32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP));
    chk("R1", 32'(req_ready), 32'd1);
    chk("R1", 32'(oe), 32'd0);
    chk("R1", 32'(rvalid), 32'd0);
    run = 1;
    // R4 R6 plain read
    issue(0, 0, 2'd1, 13'h1234, 9'h05A, '0, '0);
    // R5 R7 plain write, no masks
    issue(1, 0, 2'd2, 13'h0ABC, 9'h1F0, 64'h4444_3333_2222_1111, 8'h00);
    // R8 auto read, request raised while busy (R10)
    issue(0, 1, 2'd3, 13'h1FFF, 9'h1FF, '0, '0);
    // R8 auto write with mixed byte masks
    issue(1, 1, 2'd0, 13'h0000, 9'h000, 64'hDEAD_BEEF_0F0F_A5A5, 8'b10_01_11_00);
    repeat (3) @(negedge clk);
    // same bank, new row: closed and reopened (R10)
    issue(0, 0, 2'd2, 13'h0001, 9'h003, '0, '0);
    issue(1, 0, 2'd2, 13'h1000, 9'h100, 64'h0123_4567_89AB_CDEF, 8'b01_00_00_10);
    issue(0, 1, 2'd1, 13'h0555, 9'h0AA, '0, '0);
    issue(1, 0, 2'd3, 13'h0AAA, 9'h155, 64'hFFFF_0000_FFFF_0000, 8'hFF);
    while (cyc < free_at + CL + BL + 4) @(negedge clk);
    run = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      tests++;
      fails++;
      $display("FAIL watchdog R10: got cycle %0d expected below %0d", cyc, 5000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule